// File: doc/BRIEF.md
# Interrupt Presentation Priority Controller

This block is the per-processor presentation stage of a two-level interrupt scheme. Source controllers offer interrupts to it, each carrying a source number, a priority and an owner tag. The block keeps at most one presentation pending and drives a single interrupt line towards the processor. Lower priority numbers are more favoured, and the all-ones value is the least favoured. A better arrival displaces the pending one. Any presentation that loses, whether on arrival or later, goes back to its owner as a reject, and the owner must offer it again when a resend broadcast arrives.

The processor drives the block through single-cycle strobes. It can set its current priority threshold, set a software inter-processor interrupt (IPI) priority, accept the pending interrupt, signal end of service, and poll the state. The IPI uses a fixed source number and competes for the same pending slot as external sources, but it has no owner. Every result appears on registered outputs one cycle after its strobe. These results are read data, a reject, an end-of-service notice and the resend pulse.

Top module: `irq_present_ctrl`

## Requirements
- R1: After reset the state word (current priority in bits 31:24, pending source in bits 23:0) is 0, the IPI priority is 0xFF and `irq_out` is low. A pending-source value of 0 means nothing is pending.
- R2: A presentation whose priority is not below the current priority is rejected. `rej_valid` rises one cycle later with its source and owner, and the pending state is unchanged.
- R3: A presentation is also rejected when a source is pending whose pending priority is at or below the arriving priority.
- R4: A presentation that is not rejected becomes the pending source with its priority and owner, and `irq_out` goes high. A displaced pending source is rejected to its owner only if it has one. The IPI has no owner.
- R5: Writing the IPI priority stores it. If the new value is below the current priority and no pending source has a pending priority at or below it, source number 2 becomes pending with no owner and the IPI priority as its pending priority, and `irq_out` goes high. Any owned source it displaces is rejected.
- R6: Writing a current priority that is lower than the old one clears a pending source when the new value is at or below the pending priority. The clear sets the pending priority to 0xFF, drops `irq_out` and rejects the source to its owner if it has one.
- R7: Writing a current priority that is equal to or higher than the old one, while nothing is pending, pulses `resend_pulse` for one cycle. The IPI check of R5 runs first if the IPI priority is below the current priority.
- R8: Accept returns the full state word on `rd_word` and drops `irq_out`. The current priority becomes the old pending priority, the pending source becomes 0 and the pending priority becomes 0xFF.
- R9: End of service loads the current priority from bits 31:24 of `eoi_word` and outputs bits 23:0 on `eoi_src` with `eoi_valid`. If nothing is pending afterwards, the resend step of R7 follows in the same cycle.
- R10: Poll returns the state word and the IPI priority and changes no state.
- R11: When strobes coincide, only one is acted on, in the order accept, end of service, current-priority write, IPI write, poll, presentation. The others are dropped without any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pres_valid | input | 1 | Source presentation strobe |
| pres_src | input | 24 | Presented source number |
| pres_prio | input | 8 | Presented priority |
| pres_owner | input | 4 | Owner tag of the presenting source controller |
| cur_prio_we | input | 1 | Current-priority write strobe |
| cur_prio_val | input | 8 | New current priority |
| ipi_we | input | 1 | IPI priority write strobe |
| ipi_val | input | 8 | New IPI priority |
| accept_req | input | 1 | Accept strobe |
| eoi_req | input | 1 | End-of-service strobe |
| eoi_word | input | 32 | Priority and source word for end of service |
| poll_req | input | 1 | Poll strobe |
| irq_out | output | 1 | Interrupt line to the processor |
| rd_valid | output | 1 | Read data valid (accept or poll) |
| rd_word | output | 32 | State word returned |
| rd_ipi | output | 8 | IPI priority returned |
| rej_valid | output | 1 | Reject notice valid |
| rej_src | output | 24 | Rejected source number |
| rej_owner | output | 4 | Owner the reject is addressed to |
| eoi_valid | output | 1 | End-of-service notice valid |
| eoi_src | output | 24 | Source number whose service ended |
| resend_pulse | output | 1 | One-cycle resend broadcast |

## Verification
The assertions assume that a presented source number is never 0, because a zero source would make the interrupt line and the pending field disagree. They also assume that source controllers never present the IPI source number. The bench only presents nonzero source numbers well away from 2. It raises more than one strobe in a cycle only in the one arbitration scenario, and that scenario checks which command wins.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  parameter int unsigned PRIO_W  = 8;
  parameter int unsigned SRC_W   = 24;
  parameter int unsigned OWN_W   = 4;
  parameter int unsigned IPI_SRC = 2;
  localparam int unsigned WORD_W = PRIO_W + SRC_W;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [SRC_W-1:0]  src_t;
  typedef logic [OWN_W-1:0]  own_t;

  localparam prio_t PRIO_NONE = '1;

  typedef enum logic [2:0] {
    OP_NONE, OP_ACCEPT, OP_EOI, OP_CPRIO, OP_IPI, OP_POLL, OP_PRESENT
  } op_e;

  typedef struct packed {
    prio_t cprio;   // current processor priority
    src_t  psrc;    // pending source, 0 = none
    prio_t pprio;   // pending priority
    prio_t iprio;   // IPI priority
    logic  own_v;
    own_t  own;
    logic  irq;
  } pst_t;

  typedef struct packed {
    logic v;
    src_t src;
    own_t own;
  } rej_t;

  typedef struct packed {
    pst_t st;
    rej_t rej;
  } step_t;

  function automatic logic busy(src_t s);
    return s != '0;
  endfunction

  function automatic logic arrival_wins(pst_t s, prio_t p);
    return (p < s.cprio) && !(busy(s.psrc) && (s.pprio <= p));
  endfunction

  function automatic logic [WORD_W-1:0] state_word(pst_t s);
    return {s.cprio, s.psrc};
  endfunction

  function automatic step_t ipi_check(pst_t s);
    step_t r;
    r.st  = s;
    r.rej = '0;
    if (!(busy(s.psrc) && (s.pprio <= s.iprio))) begin
      if (busy(s.psrc) && s.own_v) begin
        r.rej.v   = 1'b1;
        r.rej.src = s.psrc;
        r.rej.own = s.own;
      end
      r.st.psrc  = src_t'(IPI_SRC);
      r.st.pprio = s.iprio;
      r.st.own_v = 1'b0;
      r.st.own   = '0;
      r.st.irq   = 1'b1;
    end
    return r;
  endfunction

  function automatic step_t resend_prep(pst_t s);
    step_t r;
    r.st  = s;
    r.rej = '0;
    if (s.iprio < s.cprio) r = ipi_check(s);
    return r;
  endfunction
endpackage

// File: rtl/ipc_cmd_sel.sv
module ipc_cmd_sel
  import ipc_pkg::*;
(
  input  logic accept_req,
  input  logic eoi_req,
  input  logic cur_prio_we,
  input  logic ipi_we,
  input  logic poll_req,
  input  logic pres_valid,
  output op_e  op
);
  always_comb begin
    if      (accept_req)  op = OP_ACCEPT;
    else if (eoi_req)     op = OP_EOI;
    else if (cur_prio_we) op = OP_CPRIO;
    else if (ipi_we)      op = OP_IPI;
    else if (poll_req)    op = OP_POLL;
    else if (pres_valid)  op = OP_PRESENT;
    else                  op = OP_NONE;
  end
endmodule

// File: rtl/ipc_engine.sv
module ipc_engine
  import ipc_pkg::*;
(
  input  op_e                op,
  input  pst_t               cur,
  input  src_t               pres_src,
  input  prio_t              pres_prio,
  input  own_t               pres_owner,
  input  prio_t              cur_prio_val,
  input  prio_t              ipi_val,
  input  logic [WORD_W-1:0]  eoi_word,
  output pst_t               nxt,
  output rej_t               rej,
  output logic               eoi_v,
  output src_t               eoi_s,
  output logic               resend,
  output logic               rd_v,
  output logic [WORD_W-1:0]  rd_w,
  output prio_t              rd_i
);
  pst_t  tmp;
  step_t stp;

  always_comb begin
    nxt    = cur;
    rej    = '0;
    eoi_v  = 1'b0;
    eoi_s  = '0;
    resend = 1'b0;
    rd_v   = 1'b0;
    rd_w   = '0;
    rd_i   = '0;
    tmp    = cur;
    stp    = '0;
    case (op)
      OP_PRESENT: begin
        if (arrival_wins(cur, pres_prio)) begin
          if (busy(cur.psrc) && cur.own_v) rej = '{1'b1, cur.psrc, cur.own};
          nxt.psrc  = pres_src;
          nxt.pprio = pres_prio;
          nxt.own_v = 1'b1;
          nxt.own   = pres_owner;
          nxt.irq   = 1'b1;
        end else begin
          rej = '{1'b1, pres_src, pres_owner};
        end
      end
      OP_IPI: begin
        tmp.iprio = ipi_val;
        nxt = tmp;
        if (ipi_val < cur.cprio) begin
          stp = ipi_check(tmp);
          nxt = stp.st;
          rej = stp.rej;
        end
      end
      OP_CPRIO: begin
        tmp.cprio = cur_prio_val;
        nxt = tmp;
        if (cur_prio_val < cur.cprio) begin
          if (busy(cur.psrc) && (cur_prio_val <= cur.pprio)) begin
            if (cur.own_v) rej = '{1'b1, cur.psrc, cur.own};
            nxt.psrc  = '0;
            nxt.pprio = PRIO_NONE;
            nxt.own_v = 1'b0;
            nxt.own   = '0;
            nxt.irq   = 1'b0;
          end
        end else if (!busy(cur.psrc)) begin
          stp    = resend_prep(tmp);
          nxt    = stp.st;
          rej    = stp.rej;
          resend = 1'b1;
        end
      end
      OP_ACCEPT: begin
        rd_v      = 1'b1;
        rd_w      = state_word(cur);
        rd_i      = cur.iprio;
        nxt.cprio = cur.pprio;
        nxt.psrc  = '0;
        nxt.pprio = PRIO_NONE;
        nxt.own_v = 1'b0;
        nxt.own   = '0;
        nxt.irq   = 1'b0;
      end
      OP_EOI: begin
        tmp.cprio = eoi_word[WORD_W-1:SRC_W];
        nxt   = tmp;
        eoi_v = 1'b1;
        eoi_s = eoi_word[SRC_W-1:0];
        if (!busy(cur.psrc)) begin
          stp    = resend_prep(tmp);
          nxt    = stp.st;
          rej    = stp.rej;
          resend = 1'b1;
        end
      end
      OP_POLL: begin
        rd_v = 1'b1;
        rd_w = state_word(cur);
        rd_i = cur.iprio;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_present_ctrl.sv
module irq_present_ctrl
  import ipc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pres_valid,
  input  logic [SRC_W-1:0]           pres_src,
  input  logic [PRIO_W-1:0]          pres_prio,
  input  logic [OWN_W-1:0]           pres_owner,
  input  logic                       cur_prio_we,
  input  logic [PRIO_W-1:0]          cur_prio_val,
  input  logic                       ipi_we,
  input  logic [PRIO_W-1:0]          ipi_val,
  input  logic                       accept_req,
  input  logic                       eoi_req,
  input  logic [PRIO_W+SRC_W-1:0]    eoi_word,
  input  logic                       poll_req,
  output logic                       irq_out,
  output logic                       rd_valid,
  output logic [PRIO_W+SRC_W-1:0]    rd_word,
  output logic [PRIO_W-1:0]          rd_ipi,
  output logic                       rej_valid,
  output logic [SRC_W-1:0]           rej_src,
  output logic [OWN_W-1:0]           rej_owner,
  output logic                       eoi_valid,
  output logic [SRC_W-1:0]           eoi_src,
  output logic                       resend_pulse
);
  op_e                sel_op;
  pst_t               st_q, st_d;
  rej_t               rej_d, rej_q;
  logic               eoi_v_d, eoi_v_q;
  src_t               eoi_s_d, eoi_s_q;
  logic               resend_d, resend_q;
  logic               rd_v_d, rd_v_q;
  logic [WORD_W-1:0]  rd_w_d, rd_w_q;
  prio_t              rd_i_d, rd_i_q;

  // named views of the state for the checker
  prio_t cur_cprio, cur_pprio;
  src_t  cur_psrc;
  assign cur_cprio = st_q.cprio;
  assign cur_pprio = st_q.pprio;
  assign cur_psrc  = st_q.psrc;

  ipc_cmd_sel u_sel (
    .accept_req (accept_req),
    .eoi_req    (eoi_req),
    .cur_prio_we(cur_prio_we),
    .ipi_we     (ipi_we),
    .poll_req   (poll_req),
    .pres_valid (pres_valid),
    .op         (sel_op)
  );

  ipc_engine u_eng (
    .op          (sel_op),
    .cur         (st_q),
    .pres_src    (pres_src),
    .pres_prio   (pres_prio),
    .pres_owner  (pres_owner),
    .cur_prio_val(cur_prio_val),
    .ipi_val     (ipi_val),
    .eoi_word    (eoi_word),
    .nxt         (st_d),
    .rej         (rej_d),
    .eoi_v       (eoi_v_d),
    .eoi_s       (eoi_s_d),
    .resend      (resend_d),
    .rd_v        (rd_v_d),
    .rd_w        (rd_w_d),
    .rd_i        (rd_i_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q.cprio <= '0;
      st_q.psrc  <= '0;
      st_q.pprio <= PRIO_NONE;
      st_q.iprio <= PRIO_NONE;
      st_q.own_v <= 1'b0;
      st_q.own   <= '0;
      st_q.irq   <= 1'b0;
      rej_q      <= '0;
      eoi_v_q    <= 1'b0;
      eoi_s_q    <= '0;
      resend_q   <= 1'b0;
      rd_v_q     <= 1'b0;
      rd_w_q     <= '0;
      rd_i_q     <= '0;
    end else begin
      st_q     <= st_d;
      rej_q    <= rej_d;
      eoi_v_q  <= eoi_v_d;
      eoi_s_q  <= eoi_s_d;
      resend_q <= resend_d;
      rd_v_q   <= rd_v_d;
      rd_w_q   <= rd_w_d;
      rd_i_q   <= rd_i_d;
    end
  end

  assign irq_out      = st_q.irq;
  assign rd_valid     = rd_v_q;
  assign rd_word      = rd_w_q;
  assign rd_ipi       = rd_i_q;
  assign rej_valid    = rej_q.v;
  assign rej_src      = rej_q.src;
  assign rej_owner    = rej_q.own;
  assign eoi_valid    = eoi_v_q;
  assign eoi_src      = eoi_s_q;
  assign resend_pulse = resend_q;
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker
  import ipc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input op_e                sel_op,
  input src_t               pres_src,
  input prio_t              pres_prio,
  input logic [WORD_W-1:0]  eoi_word,
  input prio_t              cur_cprio,
  input prio_t              cur_pprio,
  input src_t               cur_psrc,
  input logic               irq_out,
  input logic               rd_valid,
  input logic               rej_valid,
  input src_t               rej_src,
  input logic               eoi_valid,
  input src_t               eoi_src
);
  // R6 / R8: the line is high exactly while a source is pending
  a_r6_line_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (cur_psrc != '0));

  a_r2_weak_arrival_bounced: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_op == OP_PRESENT && pres_prio >= cur_cprio)
    |=> rej_valid && rej_src == $past(pres_src) && $stable(cur_psrc));

  a_r4_arrival_into_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_op == OP_PRESENT && pres_prio < cur_cprio && cur_psrc == '0)
    |=> irq_out && !rej_valid && cur_psrc == $past(pres_src));

  a_r8_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_op == OP_ACCEPT)
    |=> rd_valid && !irq_out && cur_psrc == '0 && cur_cprio == $past(cur_pprio));

  a_r9_eoi_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_op == OP_EOI)
    |=> eoi_valid && eoi_src == $past(eoi_word[SRC_W-1:0])
        && cur_cprio == $past(eoi_word[WORD_W-1:SRC_W]));

  a_r10_poll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_op == OP_POLL)
    |=> rd_valid && !rej_valid && $stable(cur_psrc) && $stable(cur_cprio)
        && $stable(cur_pprio));
endmodule

bind irq_present_ctrl ipc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_op   (sel_op),
  .pres_src (pres_src),
  .pres_prio(pres_prio),
  .eoi_word (eoi_word),
  .cur_cprio(cur_cprio),
  .cur_pprio(cur_pprio),
  .cur_psrc (cur_psrc),
  .irq_out  (irq_out),
  .rd_valid (rd_valid),
  .rej_valid(rej_valid),
  .rej_src  (rej_src),
  .eoi_valid(eoi_valid),
  .eoi_src  (eoi_src)
);

// File: tb/sim_irq_present_ctrl.sv
`timescale 1ns/1ps
module sim_irq_present_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pres_valid = 1'b0;
  logic [23:0] pres_src = '0;
  logic [7:0]  pres_prio = '0;
  logic [3:0]  pres_owner = '0;
  logic        cur_prio_we = 1'b0;
  logic [7:0]  cur_prio_val = '0;
  logic        ipi_we = 1'b0;
  logic [7:0]  ipi_val = '0;
  logic        accept_req = 1'b0;
  logic        eoi_req = 1'b0;
  logic [31:0] eoi_word = '0;
  logic        poll_req = 1'b0;
  logic        irq_out, rd_valid, rej_valid, eoi_valid, resend_pulse;
  logic [31:0] rd_word;
  logic [7:0]  rd_ipi;
  logic [23:0] rej_src, eoi_src;
  logic [3:0]  rej_owner;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_present_ctrl u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic tick();
    @(negedge clk);
    pres_valid = 0; cur_prio_we = 0; ipi_we = 0;
    accept_req = 0; eoi_req = 0; poll_req = 0;
  endtask

  task automatic present(input logic [23:0] s, input logic [7:0] p, input logic [3:0] o);
    pres_valid = 1; pres_src = s; pres_prio = p; pres_owner = o; tick();
  endtask
  task automatic wr_cur(input logic [7:0] v);
    cur_prio_we = 1; cur_prio_val = v; tick();
  endtask
  task automatic wr_ipi(input logic [7:0] v);
    ipi_we = 1; ipi_val = v; tick();
  endtask
  task automatic accept();
    accept_req = 1; tick();
  endtask
  task automatic eoi(input logic [31:0] w);
    eoi_req = 1; eoi_word = w; tick();
  endtask
  task automatic poll_expect(input string tag, input logic [31:0] w, input logic [7:0] ip);
    poll_req = 1; tick();
    eq({tag, " rd_valid"}, rd_valid, 1);
    eq({tag, " word"}, rd_word, w);
    eq({tag, " ipi"}, rd_ipi, ip);
  endtask

  task automatic t_reset();
    poll_expect("R1 reset", 32'h0, 8'hFF);
    eq("R1 irq low", irq_out, 0);
  endtask

  task automatic t_open_and_bounce();
    wr_cur(8'hFF);
    eq("R7 resend on raise", resend_pulse, 1);
    eq("R7 no irq", irq_out, 0);
    present(24'd100, 8'hFF, 4'd3);
    eq("R2 reject", rej_valid, 1);
    eq("R2 src", rej_src, 100);
    eq("R2 owner", rej_owner, 3);
    wr_cur(8'h80);
    eq("R7 no resend on lower", resend_pulse, 0);
    present(24'd101, 8'h90, 4'd1);
    eq("R2 reject below", rej_valid, 1);
    eq("R2 irq low", irq_out, 0);
  endtask

  task automatic t_win_and_displace();
    present(24'd200, 8'h40, 4'd5);
    eq("R4 irq high", irq_out, 1);
    eq("R4 no reject", rej_valid, 0);
    poll_expect("R10 poll1", 32'h800000C8, 8'hFF);
    poll_expect("R10 poll2", 32'h800000C8, 8'hFF);
    present(24'd201, 8'h40, 4'd6);
    eq("R3 reject equal", rej_valid, 1);
    eq("R3 src", rej_src, 201);
    poll_expect("R3 unchanged", 32'h800000C8, 8'hFF);
    present(24'd202, 8'h30, 4'd7);
    eq("R4 displaced rejected", rej_valid, 1);
    eq("R4 displaced src", rej_src, 200);
    eq("R4 displaced owner", rej_owner, 5);
    poll_expect("R4 new pending", 32'h800000CA, 8'hFF);
  endtask

  task automatic t_accept_eoi();
    accept();
    eq("R8 rd_valid", rd_valid, 1);
    eq("R8 word", rd_word, 32'h800000CA);
    eq("R8 irq low", irq_out, 0);
    poll_expect("R8 after", 32'h30000000, 8'hFF);
    eoi(32'hFF0000CA);
    eq("R9 eoi_valid", eoi_valid, 1);
    eq("R9 eoi_src", eoi_src, 24'hCA);
    eq("R9 resend", resend_pulse, 1);
    poll_expect("R9 prio loaded", 32'hFF000000, 8'hFF);
  endtask

  task automatic t_ipi();
    wr_ipi(8'h50);
    eq("R5 irq", irq_out, 1);
    eq("R5 no reject", rej_valid, 0);
    poll_expect("R5 ipi pending", 32'hFF000002, 8'h50);
    present(24'd300, 8'h20, 4'd9);
    eq("R4 ownerless displaced", rej_valid, 0);
    poll_expect("R4 over ipi", 32'hFF00012C, 8'h50);
    wr_ipi(8'h60);
    eq("R5 no check win", rej_valid, 0);
    poll_expect("R5 kept", 32'hFF00012C, 8'h60);
    wr_ipi(8'h10);
    eq("R5 rejects owned", rej_valid, 1);
    eq("R5 rej src", rej_src, 300);
    eq("R5 rej owner", rej_owner, 9);
    poll_expect("R5 ipi back", 32'hFF000002, 8'h10);
  endtask

  task automatic t_cur_prio();
    wr_cur(8'h10);
    eq("R6 ipi cleared irq", irq_out, 0);
    eq("R6 no owner reject", rej_valid, 0);
    poll_expect("R6 cleared", 32'h10000000, 8'h10);
    wr_cur(8'h80);
    eq("R7 resend", resend_pulse, 1);
    eq("R7 ipi first", irq_out, 1);
    poll_expect("R7 ipi pending", 32'h80000002, 8'h10);
    wr_ipi(8'hFF);
    accept();
    eoi(32'h80000002);
    eq("R9 resend empty", resend_pulse, 1);
    eq("R9 irq low", irq_out, 0);
    present(24'd400, 8'h50, 4'd2);
    eq("R4 win", irq_out, 1);
    wr_cur(8'h60);
    eq("R6 above pending keeps", irq_out, 1);
    eq("R6 no reject", rej_valid, 0);
    wr_cur(8'h50);
    eq("R6 cleared", irq_out, 0);
    eq("R6 reject", rej_valid, 1);
    eq("R6 rej src", rej_src, 400);
    eq("R6 rej owner", rej_owner, 2);
  endtask

  task automatic t_arbitration();
    accept_req = 1; poll_req = 1;
    pres_valid = 1; pres_src = 24'd500; pres_prio = 8'h10; pres_owner = 4'd1;
    tick();
    eq("R11 accept word", rd_word, 32'h50000000);
    eq("R11 present dropped irq", irq_out, 0);
    eq("R11 present dropped rej", rej_valid, 0);
    poll_expect("R11 accept applied", 32'hFF000000, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_open_and_bounce();
    t_win_and_displace();
    t_accept_eoi();
    t_ipi();
    t_cur_prio();
    t_arbitration();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule